// File: doc/BRIEF.md
# Vulnerability-Threshold Hop Decision Unit

This unit makes the run-here-or-migrate decision for a procedure in a shared-memory cluster of processor cores. A request carries a procedure number, the core's sampled supply voltage in millivolts and its die temperature in degrees Celsius. The unit rounds that reading to one of four characterized operating points. It then reads that procedure's vulnerability score for the point from an internal table and compares the score with a programmable threshold.

The same lookup serves both sides of a migration. A core that is about to call a procedure uses caller mode, where the result means "migrate". A core that receives a migration request uses callee mode, where the result means "accept". Software loads the table and the threshold through write ports before it issues requests. Scores and the threshold are unsigned fractions, with the all-ones code standing for 1.0.

Top module: `hop_decide_unit`

## Requirements
- R1: After reset, rsp_valid is 0, every table score is 0 and the threshold equals THR_RESET (default 128).
- R2: The voltage is rounded to a rail: below 855 mV is the 0.81 V rail, 855 to 944 mV is point 2 (0.90 V, 25 °C), and 945 mV or more is point 3 (0.99 V, 125 °C). Readings outside the characterized range fall into the nearest class.
- R3: On the 0.81 V rail, a temperature below 43 °C (signed compare) gives point 0 (-40 °C) and 43 °C or more gives point 1 (125 °C).
- R4: A table write with tbl_wr_en stores tbl_wr_score for the pair (tbl_wr_proc, tbl_wr_point). A later request for that procedure that rounds to that point returns the stored score on rsp_score.
- R5: In caller mode (req_mode = 0), rsp_take is 1 (migrate) exactly when the score is greater than or equal to the threshold.
- R6: In callee mode (req_mode = 1), rsp_take is 1 (accept) exactly when the score is less than or equal to the threshold. Otherwise the request is declined.
- R7: Each request with req_valid produces rsp_valid in the next cycle only. rsp_mode echoes req_mode, and rsp_point gives the rounded point index.
- R8: A threshold write with thr_wr_en applies to requests from the next cycle on. A request in the same cycle as the write uses the previous threshold.
- R9: A table write changes only its own (procedure, point) entry.
- R10: A request that coincides with a table write to the same entry returns the old score. The next request returns the new score.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tbl_wr_en | input | 1 | Table write strobe |
| tbl_wr_proc | input | PROC_W | Procedure number for the table write |
| tbl_wr_point | input | 2 | Operating point index for the table write |
| tbl_wr_score | input | SCORE_W | Score to store |
| thr_wr_en | input | 1 | Threshold write strobe |
| thr_wr_value | input | SCORE_W | New threshold |
| req_valid | input | 1 | Decision request strobe |
| req_proc | input | PROC_W | Procedure number to evaluate |
| req_mode | input | 1 | 0 = caller check, 1 = callee check |
| req_mv | input | V_W | Sampled supply voltage in mV |
| req_temp | input | T_W | Sampled temperature in °C, two's complement |
| rsp_valid | output | 1 | Decision valid, one cycle after the request |
| rsp_mode | output | 1 | Mode of the request being answered |
| rsp_take | output | 1 | Caller: migrate; callee: accept |
| rsp_point | output | 2 | Operating point the reading rounded to |
| rsp_score | output | SCORE_W | Score that was compared |

## Verification
The embedded assertions check the timing every cycle. Each request is answered exactly one cycle later, and nothing is answered without a request. They also check that the reported point agrees with the voltage and temperature that were sampled. They check the equality rule and the strictly-above rule of each mode against the threshold that was live when the request was taken, and that every table or threshold write is visible in the next cycle. Only the bench scenarios can show the following. The right score comes back for every (procedure, point) pair, and a write leaves its neighbours untouched. A write in the same cycle as a read yields the old value. The mode-dependent decisions hold across full sweeps of thresholds and boundary readings.

// File: rtl/hop_pkg.sv
package hop_pkg;

   localparam int NUM_OP_POINTS = 4;
   localparam int OP_IDX_W      = 2;

   typedef enum logic {
      MODE_CALLER = 1'b0,
      MODE_CALLEE = 1'b1
   } hop_mode_e;

   typedef enum logic [OP_IDX_W-1:0] {
      OP_LOWV_COLD = 2'd0,
      OP_LOWV_HOT  = 2'd1,
      OP_MIDV_ROOM = 2'd2,
      OP_HIGHV_HOT = 2'd3
   } op_point_e;

endpackage

// File: rtl/hop_op_quantizer.sv
module hop_op_quantizer
   import hop_pkg::*;
#(
   parameter int V_W         = 10,
   parameter int T_W         = 9,
   parameter int LOW_MID_MV  = 855,
   parameter int MID_HIGH_MV = 945,
   parameter int COLD_HOT_C  = 43
) (
   input  logic [V_W-1:0]        mv,
   input  logic signed [T_W-1:0] temp,
   output op_point_e             point
);

   localparam logic [V_W-1:0]        LM_B = V_W'(LOW_MID_MV);
   localparam logic [V_W-1:0]        MH_B = V_W'(MID_HIGH_MV);
   localparam logic signed [T_W-1:0] CH_B = T_W'(COLD_HOT_C);

   if (LOW_MID_MV >= MID_HIGH_MV) begin : g_bad_order
      $error("hop_op_quantizer: voltage boundaries out of order");
   end
   if (MID_HIGH_MV >= (1 << V_W)) begin : g_bad_vw
      $error("hop_op_quantizer: boundary does not fit V_W");
   end
   if (COLD_HOT_C >= (1 << (T_W - 1)) || COLD_HOT_C < -(1 << (T_W - 1))) begin : g_bad_tw
      $error("hop_op_quantizer: temperature boundary does not fit T_W");
   end

   logic is_low_rail;
   logic is_high_rail;
   logic is_cold;

   always_comb begin
      is_low_rail  = (mv < LM_B);
      is_high_rail = (mv >= MH_B);
      is_cold      = (temp < CH_B);
   end

   always_comb begin
      if (is_high_rail) begin
         point = OP_HIGHV_HOT;
      end else if (!is_low_rail) begin
         point = OP_MIDV_ROOM;
      end else if (is_cold) begin
         point = OP_LOWV_COLD;
      end else begin
         point = OP_LOWV_HOT;
      end
   end

endmodule

// File: rtl/hop_score_table.sv
module hop_score_table
   import hop_pkg::*;
#(
   parameter int NUM_PROCS   = 16,
   parameter int PROC_W      = 4,
   parameter int SCORE_W     = 8,
   parameter bit RESET_TABLE = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [PROC_W-1:0]  wr_proc,
   input  op_point_e          wr_point,
   input  logic [SCORE_W-1:0] wr_score,
   input  logic [PROC_W-1:0]  rd_proc,
   input  op_point_e          rd_point,
   output logic [SCORE_W-1:0] rd_score
);

   localparam int ENTRIES = NUM_PROCS * NUM_OP_POINTS;
   localparam int IDX_W   = PROC_W + OP_IDX_W;
   localparam bit FULL_IDX = (NUM_PROCS == (1 << PROC_W));

   if (NUM_PROCS > (1 << PROC_W) || NUM_PROCS < 1) begin : g_bad_procs
      $error("hop_score_table: NUM_PROCS does not fit PROC_W");
   end
   if (ENTRIES > 4096) begin : g_too_big
      $error("hop_score_table: table too large");
   end

   logic [SCORE_W-1:0] mem [ENTRIES];
   logic [IDX_W-1:0]   wr_idx;
   logic [IDX_W-1:0]   rd_idx;
   logic               wr_ok;
   logic               rd_ok;

   assign wr_idx = {wr_proc, wr_point};
   assign rd_idx = {rd_proc, rd_point};

   if (FULL_IDX) begin : g_full_range
      assign wr_ok = wr_en;
      assign rd_ok = 1'b1;
   end else begin : g_part_range
      assign wr_ok = wr_en && (int'(wr_proc) < NUM_PROCS);
      assign rd_ok = (int'(rd_proc) < NUM_PROCS);
   end

   for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
      if (RESET_TABLE) begin : g_rst
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               mem[e] <= '0;
            end else if (wr_ok && (wr_idx == IDX_W'(e))) begin
               mem[e] <= wr_score;
            end
         end
      end else begin : g_norst
         always_ff @(posedge clk) begin
            if (wr_ok && (wr_idx == IDX_W'(e))) begin
               mem[e] <= wr_score;
            end
         end
      end
   end

   always_comb begin
      rd_score = '0;
      if (rd_ok) begin
         rd_score = mem[rd_idx];
      end
   end

   AST_TABLE_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ok |=> (mem[$past(wr_idx)] == $past(wr_score))); // R4

endmodule

// File: rtl/hop_threshold_eval.sv
module hop_threshold_eval
   import hop_pkg::*;
#(
   parameter int SCORE_W   = 8,
   parameter int THR_RESET = 128
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               thr_wr_en,
   input  logic [SCORE_W-1:0] thr_wr_value,
   input  hop_mode_e          mode,
   input  logic [SCORE_W-1:0] score,
   output logic [SCORE_W-1:0] thr_q,
   output logic               take
);

   if (THR_RESET < 0 || THR_RESET >= (1 << SCORE_W)) begin : g_bad_thr
      $error("hop_threshold_eval: THR_RESET does not fit SCORE_W");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         thr_q <= SCORE_W'(THR_RESET);
      end else if (thr_wr_en) begin
         thr_q <= thr_wr_value;
      end
   end

   logic at_or_above;
   logic at_or_below;

   always_comb begin
      at_or_above = (score >= thr_q);
      at_or_below = (score <= thr_q);
      take = (mode == MODE_CALLER) ? at_or_above : at_or_below;
   end

   AST_THR_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
      thr_wr_en |=> (thr_q == $past(thr_wr_value))); // R8

endmodule

// File: rtl/hop_decide_unit.sv
module hop_decide_unit
   import hop_pkg::*;
#(
   parameter int NUM_PROCS   = 16,
   parameter int PROC_W      = (NUM_PROCS > 1) ? $clog2(NUM_PROCS) : 1,
   parameter int SCORE_W     = 8,
   parameter int V_W         = 10,
   parameter int T_W         = 9,
   parameter int LOW_MID_MV  = 855,
   parameter int MID_HIGH_MV = 945,
   parameter int COLD_HOT_C  = 43,
   parameter int THR_RESET   = 128,
   parameter bit RESET_TABLE = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tbl_wr_en,
   input  logic [PROC_W-1:0]  tbl_wr_proc,
   input  logic [1:0]         tbl_wr_point,
   input  logic [SCORE_W-1:0] tbl_wr_score,
   input  logic               thr_wr_en,
   input  logic [SCORE_W-1:0] thr_wr_value,
   input  logic               req_valid,
   input  logic [PROC_W-1:0]  req_proc,
   input  logic               req_mode,
   input  logic [V_W-1:0]     req_mv,
   input  logic [T_W-1:0]     req_temp,
   output logic               rsp_valid,
   output logic               rsp_mode,
   output logic               rsp_take,
   output logic [1:0]         rsp_point,
   output logic [SCORE_W-1:0] rsp_score
);

   if (SCORE_W < 2 || SCORE_W > 16) begin : g_bad_score
      $error("hop_decide_unit: SCORE_W out of range");
   end
   if (NUM_PROCS < 2) begin : g_bad_np
      $error("hop_decide_unit: need at least two procedures");
   end

   hop_mode_e          mode_in;
   op_point_e          point_c;
   logic [SCORE_W-1:0] score_c;
   logic [SCORE_W-1:0] thr_live;
   logic               take_c;

   assign mode_in = hop_mode_e'(req_mode);

   hop_op_quantizer #(
      .V_W         (V_W),
      .T_W         (T_W),
      .LOW_MID_MV  (LOW_MID_MV),
      .MID_HIGH_MV (MID_HIGH_MV),
      .COLD_HOT_C  (COLD_HOT_C)
   ) u_quant (
      .mv    (req_mv),
      .temp  (req_temp),
      .point (point_c)
   );

   hop_score_table #(
      .NUM_PROCS   (NUM_PROCS),
      .PROC_W      (PROC_W),
      .SCORE_W     (SCORE_W),
      .RESET_TABLE (RESET_TABLE)
   ) u_table (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (tbl_wr_en),
      .wr_proc  (tbl_wr_proc),
      .wr_point (op_point_e'(tbl_wr_point)),
      .wr_score (tbl_wr_score),
      .rd_proc  (req_proc),
      .rd_point (point_c),
      .rd_score (score_c)
   );

   hop_threshold_eval #(
      .SCORE_W   (SCORE_W),
      .THR_RESET (THR_RESET)
   ) u_thr (
      .clk          (clk),
      .rst_n        (rst_n),
      .thr_wr_en    (thr_wr_en),
      .thr_wr_value (thr_wr_value),
      .mode         (mode_in),
      .score        (score_c),
      .thr_q        (thr_live),
      .take         (take_c)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_mode  <= 1'b0;
         rsp_take  <= 1'b0;
         rsp_point <= '0;
         rsp_score <= '0;
      end else begin
         rsp_valid <= req_valid;
         if (req_valid) begin
            rsp_mode  <= req_mode;
            rsp_take  <= take_c;
            rsp_point <= point_c;
            rsp_score <= score_c;
         end
      end
   end

   AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid); // R7
   AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid); // R7
   AST_MODE_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> (rsp_mode == $past(req_mode))); // R7
   AST_HIGH_RAIL_POINT: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_point == 2'd3) |-> ($past(req_mv) >= V_W'(MID_HIGH_MV))); // R2
   AST_LOW_RAIL_POINT: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_point <= 2'd1) |-> ($past(req_mv) < V_W'(LOW_MID_MV))); // R2
   AST_COLD_POINT: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_point == 2'd0)
         |-> ($signed($past(req_temp)) < $signed(T_W'(COLD_HOT_C)))); // R3
   AST_CALLER_ABOVE_HOPS: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_mode && rsp_score > $past(thr_live)) |-> rsp_take); // R5
   AST_CALLEE_ABOVE_DECLINES: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_mode && rsp_score > $past(thr_live)) |-> !rsp_take); // R6
   AST_EQUAL_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_score == $past(thr_live)) |-> rsp_take); // R5 R6

endmodule

// File: tb/hop_decide_unit_tb.sv
module hop_decide_unit_tb;

   localparam int NP   = 16;
   localparam int PW   = 4;
   localparam int SW   = 8;
   localparam int VW   = 10;
   localparam int TW   = 9;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          tbl_wr_en = 1'b0;
   logic [PW-1:0] tbl_wr_proc = '0;
   logic [1:0]    tbl_wr_point = '0;
   logic [SW-1:0] tbl_wr_score = '0;
   logic          thr_wr_en = 1'b0;
   logic [SW-1:0] thr_wr_value = '0;
   logic          req_valid = 1'b0;
   logic [PW-1:0] req_proc = '0;
   logic          req_mode = 1'b0;
   logic [VW-1:0] req_mv = '0;
   logic [TW-1:0] req_temp = '0;
   logic          rsp_valid;
   logic          rsp_mode;
   logic          rsp_take;
   logic [1:0]    rsp_point;
   logic [SW-1:0] rsp_score;

   always #4 clk = ~clk;

   hop_decide_unit u_dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .tbl_wr_en    (tbl_wr_en),
      .tbl_wr_proc  (tbl_wr_proc),
      .tbl_wr_point (tbl_wr_point),
      .tbl_wr_score (tbl_wr_score),
      .thr_wr_en    (thr_wr_en),
      .thr_wr_value (thr_wr_value),
      .req_valid    (req_valid),
      .req_proc     (req_proc),
      .req_mode     (req_mode),
      .req_mv       (req_mv),
      .req_temp     (req_temp),
      .rsp_valid    (rsp_valid),
      .rsp_mode     (rsp_mode),
      .rsp_take     (rsp_take),
      .rsp_point    (rsp_point),
      .rsp_score    (rsp_score)
   );

   typedef struct {
      int    due;
      bit    mode;
      bit    take;
      int    point;
      int    score;
      string tag;
   } exp_t;

   exp_t  sb_q[$];
   int    checks = 0;
   int    errors = 0;
   int    cyc = 0;
   bit    done = 1'b0;
   int    model_tbl [NP*4];
   int    model_thr = 128;

   always @(posedge clk) if (rst_n) cyc <= cyc + 1;

   function automatic int quant(input int mv, input int t);
      if (mv >= 945) return 3;
      if (mv >= 855) return 2;
      if (t < 43) return 0;
      return 1;
   endfunction

   task automatic chk(input bit ok, input string tag, input int act, input int expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
      end
   endtask

   task automatic step(input bit wv, input int wp, input int wpt, input int ws,
                       input bit tv, input int tval,
                       input bit rv, input int rp, input bit rm,
                       input int mv, input int t, input string tag);
      exp_t e;
      int   pt;
      int   sc;
      @(negedge clk);
      tbl_wr_en    = wv;
      tbl_wr_proc  = PW'(wp);
      tbl_wr_point = 2'(wpt);
      tbl_wr_score = SW'(ws);
      thr_wr_en    = tv;
      thr_wr_value = SW'(tval);
      req_valid    = rv;
      req_proc     = PW'(rp);
      req_mode     = rm;
      req_mv       = VW'(mv);
      req_temp     = TW'(t);
      if (rv) begin
         pt = quant(mv, t);
         sc = model_tbl[rp*4 + pt];
         e.due   = cyc + 1;
         e.mode  = rm;
         e.take  = rm ? (sc <= model_thr) : (sc >= model_thr);
         e.point = pt;
         e.score = sc;
         e.tag   = tag;
         sb_q.push_back(e);
      end
      if (wv) model_tbl[wp*4 + wpt] = ws;
      if (tv) model_thr = tval;
   endtask

   task automatic wr(input int p, input int pt, input int s);
      step(1, p, pt, s, 0, 0, 0, 0, 0, 0, 0, "");
   endtask

   task automatic thr(input int v);
      step(0, 0, 0, 0, 1, v, 0, 0, 0, 0, 0, "");
   endtask

   task automatic req(input int p, input bit m, input int mv, input int t, input string tag);
      step(0, 0, 0, 0, 0, 0, 1, p, m, mv, t, tag);
   endtask

   task automatic idle();
      step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "");
   endtask

   function automatic int pt_mv(input int pt);
      case (pt)
         0, 1:    return 810;
         2:       return 900;
         default: return 990;
      endcase
   endfunction

   function automatic int pt_t(input int pt);
      case (pt)
         0:       return -40;
         2:       return 25;
         default: return 125;
      endcase
   endfunction

   // Monitor: pops the scoreboard as responses appear (R7 timing and fields).
   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (sb_q.size() > 0 && sb_q[0].due == cyc) begin
            exp_t e;
            e = sb_q.pop_front();
            chk(rsp_valid == 1'b1, "R7 rsp_valid", int'(rsp_valid), 1);
            chk(rsp_mode == e.mode, "R7 rsp_mode", int'(rsp_mode), int'(e.mode));
            chk(int'(rsp_point) == e.point, {e.tag, " rsp_point"}, int'(rsp_point), e.point);
            chk(int'(rsp_score) == e.score, {e.tag, " rsp_score"}, int'(rsp_score), e.score);
            chk(rsp_take == e.take, {e.tag, " rsp_take"}, int'(rsp_take), int'(e.take));
         end else begin
            chk(rsp_valid == 1'b0, "R7 no spurious rsp_valid", int'(rsp_valid), 0);
         end
      end
   end

   initial begin
      for (int i = 0; i < NP*4; i++) model_tbl[i] = 0;
      // R1: outputs quiet during reset
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         chk(rsp_valid == 1'b0, "R1 reset rsp_valid", int'(rsp_valid), 0);
      end
      @(negedge clk);
      rst_n = 1'b1;
      // R1: empty table, both modes
      for (int p = 0; p < NP; p += 5) begin
         for (int pt = 0; pt < 4; pt++) begin
            req(p, 0, pt_mv(pt), pt_t(pt), "R1");
            req(p, 1, pt_mv(pt), pt_t(pt), "R1");
         end
      end
      // R1/R5/R6: reset threshold 128 probed at its edges
      wr(1, 0, 128);
      req(1, 0, 810, -40, "R1 R5");
      req(1, 1, 810, -40, "R6");
      wr(1, 0, 127);
      req(1, 0, 810, -40, "R5");
      req(1, 1, 810, -40, "R6");
      wr(1, 0, 129);
      req(1, 0, 810, -40, "R5");
      req(1, 1, 810, -40, "R6");
      idle();
      // R4/R9: fill table, read back every entry
      for (int p = 0; p < NP; p++) begin
         for (int pt = 0; pt < 4; pt++) wr(p, pt, (p*37 + pt*61 + 11) & 255);
      end
      for (int p = 0; p < NP; p++) begin
         for (int pt = 0; pt < 4; pt++) begin
            req(p, p[0], pt_mv(pt), pt_t(pt), "R4 R9");
         end
      end
      // R9: rewrite one entry, neighbours intact
      wr(7, 2, 200);
      for (int pt = 0; pt < 4; pt++) req(7, 0, pt_mv(pt), pt_t(pt), "R9");
      req(6, 0, 900, 25, "R9");
      req(8, 0, 900, 25, "R9");
      idle();
      // R2/R3: boundary sweep
      begin
         int mvs [6] = '{600, 854, 855, 944, 945, 1023};
         int ts  [5] = '{-200, -40, 42, 43, 200};
         foreach (mvs[i]) begin
            foreach (ts[j]) req(5, 0, mvs[i], ts[j], (mvs[i] < 855) ? "R3" : "R2");
         end
      end
      idle();
      idle();
      // R8: threshold sweep, new value used from the next cycle
      begin
         int thv [3] = '{0, 255, 100};
         foreach (thv[k]) begin
            thr(thv[k]);
            for (int pt = 0; pt < 4; pt++) begin
               req(3, 0, pt_mv(pt), pt_t(pt), "R8 R5");
               req(3, 1, pt_mv(pt), pt_t(pt), "R8 R6");
            end
         end
      end
      // R8: same-cycle threshold write uses old threshold
      wr(2, 2, 150);
      thr(150);
      step(0, 0, 0, 0, 1, 149, 1, 2, 0, 900, 25, "R8 same-cycle");
      req(2, 0, 900, 25, "R8 after");
      step(0, 0, 0, 0, 1, 151, 1, 2, 1, 900, 25, "R8 same-cycle");
      req(2, 1, 900, 25, "R8 after");
      // R10: same-cycle table write and read of one entry
      step(1, 9, 3, 250, 0, 0, 1, 9, 0, 990, 125, "R10 old");
      req(9, 0, 990, 125, "R10 new");
      step(1, 9, 3, 5, 0, 0, 1, 9, 1, 990, 125, "R10 old");
      req(9, 1, 990, 125, "R10 new");
      idle();
      idle();
      idle();
      chk(sb_q.size() == 0, "R7 all answered", sb_q.size(), 0);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule